// File: doc/BRIEF.md
# Twiddle Access Reducer with Transition Detection

This block sits between the butterfly sequencer of a radix-2 in-place FFT engine and its twiddle-factor ROM. For each butterfly it receives the pass index and the butterfly counter. From these it works out which coefficient the butterfly needs. It issues a read to a quarter-size ROM only when that read would fetch a different word from the one last fetched.

The butterfly order is reordered: the counter's least significant bit is rotated to the top of the butterfly index. Because of this, the coefficient address changes slowly within a pass, and its top bit toggles every butterfly. That top bit is never sent to the ROM. Coefficients in the upper half of the range are rebuilt from the lower-quarter entry by exchanging its real and imaginary parts and negating one of them. The block outputs that top bit as a swap flag for the complex multiplier. Because the ROM's data register is not reloaded when no read is issued, a whole transform needs only 2^(n-1) ROM reads, where it would otherwise need n·2^(n-1).

Top module: `twiddle_access_reducer`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `rom_en_o`, `tw_valid_o`, `swap_o` and `rom_addr_o` are all 0.
- R2: A butterfly presented in pass 0 gives ROM address 0 and swap flag 0.
- R3: For a butterfly `b` (n-1 bits) in pass `p`, the coefficient index is k = {b[0], b[n-2:1]} with its lowest n-1-p bits forced to 0. One cycle after a valid input, `rom_addr_o` equals k[n-3:0] and `swap_o` equals k[n-2].
- R4: `rom_en_o` is 1 one cycle after a valid input when any of these holds: `start_i` is high; no read has been issued since reset; the pass differs from the pass of the previous valid input; or the ROM address differs from the previous valid input's ROM address. Otherwise `rom_en_o` is 0.
- R5: `swap_o` follows every valid butterfly, including butterflies whose ROM read is suppressed.
- R6: A full transform takes n passes of N/2 butterflies each, in counter order, with `start_i` on the first. It raises `rom_en_o` exactly 2^(n-1) times.
- R7: The caller's data register is loaded only when `rom_en_o` is 1. Entry j holds round(2^14·cos(2πj/N)) as the real part and round(-2^14·sin(2πj/N)) as the imaginary part. When `swap_o` is 1, the caller uses the stored imaginary part as the real part and the negated stored real part as the imaginary part. The result then matches cos(2πk/N) and -sin(2πk/N) within 1 LSB.
- R8: A cycle with `valid_i` low gives `rom_en_o` = 0 and `tw_valid_o` = 0. In that cycle `rom_addr_o` and `swap_o` keep their values, and the previous-read record is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Marks the first butterfly of a transform |
| valid_i | input | 1 | A butterfly is presented this cycle |
| pass_i | input | $clog2(LOG2N) | Pass index, 0 to n-1 |
| bfly_i | input | LOG2N-1 | Butterfly counter |
| rom_addr_o | output | LOG2N-2 | Quarter-size ROM address |
| rom_en_o | output | 1 | ROM read enable |
| swap_o | output | 1 | Exchange real and imaginary parts of the coefficient |
| tw_valid_o | output | 1 | The outputs belong to a valid butterfly |

## Verification
Two things can happen in the same cycle: a pass boundary or a transform start, and a ROM address that has not changed. The step from pass 0 to pass 1 both times hits address 0, and so does a `start_i` on a repeated butterfly. In each case the bench expects a read to be issued. The swap flag can also toggle in the same cycle that a read is suppressed. The bench judges this through the rebuilt coefficient: the held ROM word combined with the fresh swap flag must still give the correct cos/sin pair.

// File: rtl/twr_pkg.sv
// Shared helpers for the twiddle access reducer.
// Assumes LOG2N >= 3, so that the quarter ROM has at least two entries.
package twr_pkg;

    // Width needed to carry a pass index for a 2^log2n point transform.
    function automatic int pass_width(input int log2n);
        return (log2n <= 2) ? 1 : $clog2(log2n);
    endfunction

endpackage

// File: rtl/twr_addr_gen.sv
// Coefficient index generator.
// Rotates the butterfly counter so that its LSB becomes the index MSB,
// then clears the low (LOG2N-1-pass) bits. Purely combinational.
// Assumes pass_i < LOG2N.
module twr_addr_gen #(
    parameter int LOG2N = 5,
    parameter int PW    = twr_pkg::pass_width(LOG2N)
) (
    input  logic [PW-1:0]    pass_i,
    input  logic [LOG2N-2:0] bfly_i,
    output logic [LOG2N-3:0] rom_addr_o,
    output logic             swap_o
);
    localparam int AW = LOG2N - 1;

    logic [AW-1:0] rot;
    logic [AW-1:0] kidx;

    // Reordered butterfly index: LSB moves to the top.
    assign rot = {bfly_i[0], bfly_i[AW-1:1]};

    // Keep only the top pass_i bits of the reordered index.
    always_comb begin
        for (int i = 0; i < AW; i++) begin
            kidx[i] = rot[i] & ((i + int'(pass_i)) >= AW);
        end
    end

    assign rom_addr_o = kidx[AW-2:0];
    assign swap_o     = kidx[AW-1];
endmodule

// File: rtl/twr_change_det.sv
// Address transition detector.
// Remembers the pass and ROM address of the last valid butterfly and
// flags a read when either differs, on a transform start, or when no
// read has been issued since reset.
module twr_change_det #(
    parameter int LOG2N = 5,
    parameter int PW    = twr_pkg::pass_width(LOG2N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             start_i,
    input  logic [PW-1:0]    pass_i,
    input  logic [LOG2N-3:0] rom_addr_i,
    output logic             fire_o
);
    logic             seen_q;
    logic [PW-1:0]    pass_q;
    logic [LOG2N-3:0] addr_q;

    // Decide whether this butterfly needs a fresh ROM word.
    assign fire_o = valid_i &&
                    (start_i || !seen_q || (pass_i != pass_q) || (rom_addr_i != addr_q));

    // Record the last valid butterfly; an idle cycle leaves the record alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            pass_q <= '0;
            addr_q <= '0;
        end else if (valid_i) begin
            seen_q <= 1'b1;
            pass_q <= pass_i;
            addr_q <= rom_addr_i;
        end
    end

    // R4: a start always issues a read.
    a_r4_start_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && start_i) |-> fire_o);

    // R4: a repeated pass and address without start issues no read.
    a_r4_repeat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !start_i && seen_q && pass_i == pass_q && rom_addr_i == addr_q) |-> !fire_o);
endmodule

// File: rtl/twiddle_access_reducer.sv
// Twiddle access reducer: registers the ROM address, the gated read
// enable and the swap flag for each butterfly of the reordered stream.
// Latency is one cycle. The ROM and the multiplier are external.
module twiddle_access_reducer #(
    parameter int LOG2N = 5,
    parameter int PW    = twr_pkg::pass_width(LOG2N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic [PW-1:0]    pass_i,
    input  logic [LOG2N-2:0] bfly_i,
    output logic [LOG2N-3:0] rom_addr_o,
    output logic             rom_en_o,
    output logic             swap_o,
    output logic             tw_valid_o
);
    logic [LOG2N-3:0] addr_c;
    logic             swap_c;
    logic             fire_c;

    twr_addr_gen #(.LOG2N(LOG2N), .PW(PW)) u_addr (
        .pass_i     (pass_i),
        .bfly_i     (bfly_i),
        .rom_addr_o (addr_c),
        .swap_o     (swap_c)
    );

    twr_change_det #(.LOG2N(LOG2N), .PW(PW)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .start_i    (start_i),
        .pass_i     (pass_i),
        .rom_addr_i (addr_c),
        .fire_o     (fire_c)
    );

    // Output register: address and swap update only on valid butterflies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_addr_o <= '0;
            swap_o     <= 1'b0;
            rom_en_o   <= 1'b0;
            tw_valid_o <= 1'b0;
        end else begin
            rom_en_o   <= fire_c;
            tw_valid_o <= valid_i;
            if (valid_i) begin
                rom_addr_o <= addr_c;
                swap_o     <= swap_c;
            end
        end
    end

    // R1: reset clears the read and valid outputs.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!rom_en_o && !tw_valid_o));

    // R2: pass 0 always addresses entry 0 without a swap.
    a_r2_pass0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pass_i == '0) |=> (rom_addr_o == '0 && !swap_o));

    // R8: an idle cycle never issues a read.
    a_r8_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !tw_valid_o |-> !rom_en_o);

    // R8: an idle input leaves address and swap unchanged.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(rom_addr_o) && $stable(swap_o)));
endmodule

// File: tb/test_twiddle_access_reducer.sv
module test_twiddle_access_reducer;
    localparam int LG = 5;
    localparam int N  = 1 << LG;
    localparam int PW = twr_pkg::pass_width(LG);
    localparam int Q4 = N / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          valid_i = 1'b0;
    logic [PW-1:0] pass_i = '0;
    logic [LG-2:0] bfly_i = '0;
    logic [LG-3:0] rom_addr_o;
    logic          rom_en_o, swap_o, tw_valid_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    twiddle_access_reducer #(.LOG2N(LG)) i_twiddle_access_reducer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .pass_i(pass_i), .bfly_i(bfly_i), .rom_addr_o(rom_addr_o),
        .rom_en_o(rom_en_o), .swap_o(swap_o), .tw_valid_o(tw_valid_o)
    );

    function automatic int rnd(real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    // Behavioural quarter-size ROM with a data register loaded on enable.
    int rom_re [Q4];
    int rom_im [Q4];
    int q_re = 0, q_im = 0;
    logic sw_d = 1'b0, vl_d = 1'b0;
    always @(posedge clk) begin
        if (rom_en_o) begin
            q_re <= rom_re[rom_addr_o];
            q_im <= rom_im[rom_addr_o];
        end
        sw_d <= swap_o;
        vl_d <= tw_valid_o;
    end

    // Reference model state.
    int  m_addr = 0, m_swap = 0, m_pass = 0, m_last = 0;
    bit  m_seen = 0;
    int  pend_k = -1;
    int  en_count = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One butterfly (or idle cycle), then compare outputs and the coefficient.
    task automatic step(input bit v, input bit st, input int p, input int b);
        int rot, k, e_en;
        valid_i = v; start_i = st; pass_i = PW'(p); bfly_i = (LG-1)'(b);
        e_en = 0;
        if (v) begin
            rot = ((b & 1) << (LG - 2)) | (b >> 1);
            k   = (rot >> (LG - 1 - p)) << (LG - 1 - p);
            e_en = (st || !m_seen || p != m_pass || (k % Q4) != m_last) ? 1 : 0;
            m_addr = k % Q4; m_swap = k / Q4;
            m_seen = 1; m_pass = p; m_last = m_addr;
        end
        @(posedge clk);
        @(negedge clk);
        // R7: coefficient of the previous butterfly, through the held ROM word.
        if (pend_k >= 0) begin
            int er, ei, ar, ai;
            er = rnd(16384.0 * $cos(2.0 * 3.14159265358979 * pend_k / N));
            ei = rnd(-16384.0 * $sin(2.0 * 3.14159265358979 * pend_k / N));
            ar = sw_d ? q_im : q_re;
            ai = sw_d ? -q_re : q_im;
            chk(vl_d && (ar - er <= 1) && (er - ar <= 1), "R7 real", ar, er);
            chk((ai - ei <= 1) && (ei - ai <= 1), "R7 imag", ai, ei);
        end
        pend_k = v ? k : -1;
        chk(rom_en_o == e_en, "R4 rom_en", rom_en_o, e_en);
        chk(tw_valid_o == v, "R8 tw_valid", tw_valid_o, v);
        chk(rom_addr_o == m_addr, v ? "R3 rom_addr" : "R8 addr hold", rom_addr_o, m_addr);
        chk(swap_o == m_swap, v ? "R5 swap" : "R8 swap hold", swap_o, m_swap);
        if (v && p == 0) chk(rom_addr_o == 0 && swap_o == 0, "R2 pass0", rom_addr_o, 0);
        if (rom_en_o) en_count++;
    endtask

    task automatic transform();
        en_count = 0;
        for (int p = 0; p < LG; p++)
            for (int b = 0; b < N / 2; b++)
                step(1'b1, (p == 0 && b == 0), p, b);
        chk(en_count == (1 << (LG - 1)), "R6 reads per transform", en_count, 1 << (LG - 1));
    endtask

    initial begin
        for (int j = 0; j < Q4; j++) begin
            rom_re[j] = rnd(16384.0 * $cos(2.0 * 3.14159265358979 * j / N));
            rom_im[j] = rnd(-16384.0 * $sin(2.0 * 3.14159265358979 * j / N));
        end
    end

    initial begin : watchdog
        #200000;
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rom_en_o == 0 && tw_valid_o == 0 && swap_o == 0 && rom_addr_o == 0,
            "R1 reset state", {rom_en_o, tw_valid_o, swap_o}, 0);
        rst_n = 1'b1;
        transform();
        transform();
        // R8: idle gap between identical butterflies issues no new read.
        step(1'b1, 1'b0, 3, 5);
        step(1'b0, 1'b0, 0, 0);
        step(1'b0, 1'b0, 4, 7);
        step(1'b1, 1'b0, 3, 5);
        // R4: pass change with the same address, and start on a repeat.
        step(1'b1, 1'b1, 0, 0);
        step(1'b1, 1'b0, 1, 0);
        step(1'b1, 1'b0, 2, 3);
        step(1'b1, 1'b1, 2, 3);
        // R3, R5: descending order in the last pass.
        for (int b = N / 2 - 1; b >= 0; b -= 3) step(1'b1, 1'b0, LG - 1, b);
        step(1'b0, 1'b0, 0, 0);
        step(1'b0, 1'b0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule